// File: doc/BRIEF.md
# Ring Node Forwarding Arbiter

This block is the packet path of one node on a one-way ring of nodes. Single-beat packets arrive from the upstream neighbour on a valid/ready stream. Each packet carries the ID of the node that sent it, an address, a data word and a flag that marks a transmission error. Foreign packets without errors are passed downstream unchanged. They are also written to the node's local copy of shared memory through a one-cycle write port. A packet that comes back to the node that sent it has been all the way round the ring. It is absorbed, and it proves that the loop is closed. Errored packets are removed from the ring and can raise an interrupt.

Packets written by the local host are placed into free slots between pass-through packets. Pass-through traffic always has priority. Since every packet is one beat, a local packet can only go out at a packet boundary. The block times the gap between sending a local packet and that packet coming back, so the host can read the latency of the loop. It also keeps a sticky flag showing that the ring is intact, which the host clears.

Top module: `ring_fwd_node`

## Requirements
- R1: `node_id_o` presents the configured `node_id_i` one cycle later. It is 0 while reset is held.
- R2: A packet accepted from upstream whose sender ID differs from `node_id_i` and whose error flag is 0 appears on the downstream port with the same sender ID, address and data. Packets leave downstream in the order they were accepted.
- R3: A packet accepted from upstream whose sender ID equals `node_id_i` is never sent downstream and never written to local memory.
- R4: A packet accepted with its error flag at 1 is neither forwarded nor written to memory. `err_irq_o` pulses high for one cycle, in the cycle after acceptance, only when `err_irq_en_i` is 1.
- R5: While `up_valid_i` is 1, `loc_ready_o` is 0, so upstream traffic wins over local packets. A local packet goes downstream with sender ID equal to `node_id_i`.
- R6: `mem_we_o` pulses for one cycle, in the cycle after a foreign error-free packet is accepted, with that packet's address and data on `mem_addr_o` and `mem_data_o`. Local packets cause no memory write.
- R7: `ring_ok_o` is 0 after reset. It becomes 1 in the cycle after a returning own error-free packet is accepted. A cycle with `ring_clr_i` at 1 clears it, and a set in the same cycle wins. An own packet carrying an error does not set it.
- R8: `loop_lat_o` is 0 after reset. When an own error-free packet returns, it loads the number of clock edges from the accept edge of the earliest unanswered local packet to the accept edge of the returning packet.
- R9: While `dn_valid_o` is 1 and `dn_ready_i` is 0, `dn_valid_o` stays 1 in the next cycle and the downstream sender ID, address and data do not change.
- R10: After reset, `dn_valid_o`, `mem_we_o` and `err_irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id_i | input | 8 | Static node ID setting |
| err_irq_en_i | input | 1 | Enables the error interrupt |
| ring_clr_i | input | 1 | Host clear of the ring-intact flag |
| up_valid_i | input | 1 | Upstream packet valid |
| up_ready_o | output | 1 | Upstream packet accepted |
| up_src_i | input | 8 | Upstream sender ID |
| up_addr_i | input | 16 | Upstream address |
| up_data_i | input | 32 | Upstream data |
| up_err_i | input | 1 | Upstream transmission error flag |
| loc_valid_i | input | 1 | Local write packet valid |
| loc_ready_o | output | 1 | Local packet accepted |
| loc_addr_i | input | 16 | Local address |
| loc_data_i | input | 32 | Local data |
| dn_valid_o | output | 1 | Downstream packet valid |
| dn_ready_i | input | 1 | Downstream ready |
| dn_src_o | output | 8 | Downstream sender ID |
| dn_addr_o | output | 16 | Downstream address |
| dn_data_o | output | 32 | Downstream data |
| mem_we_o | output | 1 | Local memory write strobe |
| mem_addr_o | output | 16 | Local memory write address |
| mem_data_o | output | 32 | Local memory write data |
| err_irq_o | output | 1 | Error interrupt pulse |
| ring_ok_o | output | 1 | Ring-intact flag |
| loop_lat_o | output | 16 | Last measured loop latency in cycles |
| node_id_o | output | 8 | Node ID status readback |

## Verification
The hardest case to reach is a local packet contending with upstream traffic at the same boundary while the downstream side is stalled. The bench starts an upstream send and a local send in the same cycle under a back-pressure pattern. It then checks that the upstream packet goes out first, that the local packet follows, and that the output holds through every stall. Latency is measured with a manual loop-back: the bench sends a local packet, waits a known number of cycles, then returns it on the upstream port. The expected count comes from the bench's own count of accept edges.

// File: rtl/ring_pkg.sv
package ring_pkg;
  parameter int unsigned RN_ID_W   = 8;
  parameter int unsigned RN_ADDR_W = 16;
  parameter int unsigned RN_DATA_W = 32;
  parameter int unsigned RN_LAT_W  = 16;

  typedef struct packed {
    logic [RN_ID_W-1:0]   src;
    logic [RN_ADDR_W-1:0] addr;
    logic [RN_DATA_W-1:0] data;
  } pkt_t;

  typedef enum logic [1:0] {
    KIND_FWD = 2'd0,
    KIND_OWN = 2'd1,
    KIND_ERR = 2'd2
  } pkt_kind_e;
endpackage

// File: rtl/ring_classify.sv
module ring_classify
  import ring_pkg::*;
(
  input  pkt_t                 pkt_i,
  input  logic                 err_i,
  input  logic [RN_ID_W-1:0]   self_id_i,
  output pkt_kind_e            kind_o
);
  always_comb begin
    if (err_i)                       kind_o = KIND_ERR;
    else if (pkt_i.src == self_id_i) kind_o = KIND_OWN;
    else                             kind_o = KIND_FWD;
  end
endmodule

// File: rtl/ring_out_slot.sv
module ring_out_slot
  import ring_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic up_valid_i,
  input  logic up_fwd_i,
  input  pkt_t up_pkt_i,
  input  logic loc_valid_i,
  input  pkt_t loc_pkt_i,
  input  logic dn_ready_i,
  output logic up_ready_o,
  output logic loc_ready_o,
  output logic dn_valid_o,
  output pkt_t dn_pkt_o
);
  logic slot_free;
  logic up_fire;
  logic loc_fire;

  assign slot_free   = !dn_valid_o || dn_ready_i;
  assign up_ready_o  = slot_free;
  assign loc_ready_o = slot_free && !up_valid_i;
  assign up_fire     = up_valid_i && slot_free;
  assign loc_fire    = loc_valid_i && loc_ready_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid_o <= 1'b0;
      dn_pkt_o   <= '0;
    end else if (slot_free) begin
      if (up_fire) begin
        dn_valid_o <= up_fwd_i;
        if (up_fwd_i) dn_pkt_o <= up_pkt_i;
      end else if (loc_fire) begin
        dn_valid_o <= 1'b1;
        dn_pkt_o   <= loc_pkt_i;
      end else begin
        dn_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ring_loop_mon.sv
module ring_loop_mon
  import ring_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                loc_fire_i,
  input  logic                own_back_i,
  input  logic                clr_i,
  output logic                ring_ok_o,
  output logic [RN_LAT_W-1:0] lat_o
);
  logic [RN_LAT_W-1:0] free_cnt;
  logic [RN_LAT_W-1:0] stamp;
  logic                timing;

  always_ff @(posedge clk) begin
    if (rst) begin
      free_cnt  <= '0;
      stamp     <= '0;
      timing    <= 1'b0;
      ring_ok_o <= 1'b0;
      lat_o     <= '0;
    end else begin
      free_cnt <= free_cnt + 1'b1;
      if (own_back_i) begin
        ring_ok_o <= 1'b1;
      end else if (clr_i) begin
        ring_ok_o <= 1'b0;
      end
      if (own_back_i && timing) begin
        lat_o  <= free_cnt - stamp;
        timing <= 1'b0;
      end else if (loc_fire_i && !timing) begin
        stamp  <= free_cnt;
        timing <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ring_fwd_node.sv
module ring_fwd_node
  import ring_pkg::*;
#(
  parameter int unsigned ID_W   = RN_ID_W,
  parameter int unsigned ADDR_W = RN_ADDR_W,
  parameter int unsigned DATA_W = RN_DATA_W,
  parameter int unsigned LAT_W  = RN_LAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   node_id_i,
  input  logic              err_irq_en_i,
  input  logic              ring_clr_i,
  input  logic              up_valid_i,
  output logic              up_ready_o,
  input  logic [ID_W-1:0]   up_src_i,
  input  logic [ADDR_W-1:0] up_addr_i,
  input  logic [DATA_W-1:0] up_data_i,
  input  logic              up_err_i,
  input  logic              loc_valid_i,
  output logic              loc_ready_o,
  input  logic [ADDR_W-1:0] loc_addr_i,
  input  logic [DATA_W-1:0] loc_data_i,
  output logic              dn_valid_o,
  input  logic              dn_ready_i,
  output logic [ID_W-1:0]   dn_src_o,
  output logic [ADDR_W-1:0] dn_addr_o,
  output logic [DATA_W-1:0] dn_data_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              err_irq_o,
  output logic              ring_ok_o,
  output logic [LAT_W-1:0]  loop_lat_o,
  output logic [ID_W-1:0]   node_id_o
);
  pkt_t      up_pkt, loc_pkt, dn_pkt;
  pkt_kind_e up_kind;
  logic      up_fire, loc_fire;

  assign up_pkt  = '{src: up_src_i, addr: up_addr_i, data: up_data_i};
  assign loc_pkt = '{src: node_id_i, addr: loc_addr_i, data: loc_data_i};

  ring_classify u_cls (
    .pkt_i     (up_pkt),
    .err_i     (up_err_i),
    .self_id_i (node_id_i),
    .kind_o    (up_kind)
  );

  ring_out_slot u_slot (
    .clk         (clk),
    .rst         (rst),
    .up_valid_i  (up_valid_i),
    .up_fwd_i    (up_kind == KIND_FWD),
    .up_pkt_i    (up_pkt),
    .loc_valid_i (loc_valid_i),
    .loc_pkt_i   (loc_pkt),
    .dn_ready_i  (dn_ready_i),
    .up_ready_o  (up_ready_o),
    .loc_ready_o (loc_ready_o),
    .dn_valid_o  (dn_valid_o),
    .dn_pkt_o    (dn_pkt)
  );

  assign up_fire  = up_valid_i && up_ready_o;
  assign loc_fire = loc_valid_i && loc_ready_o;

  ring_loop_mon u_mon (
    .clk        (clk),
    .rst        (rst),
    .loc_fire_i (loc_fire),
    .own_back_i (up_fire && (up_kind == KIND_OWN)),
    .clr_i      (ring_clr_i),
    .ring_ok_o  (ring_ok_o),
    .lat_o      (loop_lat_o)
  );

  assign dn_src_o  = dn_pkt.src;
  assign dn_addr_o = dn_pkt.addr;
  assign dn_data_o = dn_pkt.data;

  always_ff @(posedge clk) begin
    if (rst) begin
      node_id_o  <= '0;
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
      err_irq_o  <= 1'b0;
    end else begin
      node_id_o <= node_id_i;
      mem_we_o  <= up_fire && (up_kind == KIND_FWD);
      if (up_fire && (up_kind == KIND_FWD)) begin
        mem_addr_o <= up_addr_i;
        mem_data_o <= up_data_i;
      end
      err_irq_o <= up_fire && (up_kind == KIND_ERR) && err_irq_en_i;
    end
  end
endmodule

// File: rtl/ring_fwd_node_chk.sv
module ring_fwd_node_chk #(
  parameter int unsigned ID_W   = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ID_W-1:0]   node_id_i,
  input logic              err_irq_en_i,
  input logic              up_valid_i,
  input logic              up_ready_o,
  input logic [ID_W-1:0]   up_src_i,
  input logic              up_err_i,
  input logic              loc_ready_o,
  input logic              dn_valid_o,
  input logic              dn_ready_i,
  input logic [ID_W-1:0]   dn_src_o,
  input logic [ADDR_W-1:0] dn_addr_o,
  input logic [DATA_W-1:0] dn_data_o,
  input logic              mem_we_o,
  input logic              err_irq_o,
  input logic              ring_ok_o
);
  logic up_fire;
  assign up_fire = up_valid_i && up_ready_o;

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (dn_valid_o && !dn_ready_i) |=> (dn_valid_o && $stable(dn_src_o)
      && $stable(dn_addr_o) && $stable(dn_data_o)));

  assert_up_first_R5: assert property (@(posedge clk) disable iff (rst)
    up_valid_i |-> !loc_ready_o);

  assert_own_no_write_R3: assert property (@(posedge clk) disable iff (rst)
    (up_fire && up_src_i == node_id_i) |=> !mem_we_o);

  assert_err_irq_R4: assert property (@(posedge clk) disable iff (rst)
    (up_fire && up_err_i && err_irq_en_i) |=> err_irq_o);

  assert_err_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    (up_fire && up_err_i) |=> !mem_we_o);

  assert_mem_write_R6: assert property (@(posedge clk) disable iff (rst)
    (up_fire && !up_err_i && up_src_i != node_id_i) |=> mem_we_o);

  assert_ring_ok_R7: assert property (@(posedge clk) disable iff (rst)
    (up_fire && !up_err_i && up_src_i == node_id_i) |=> ring_ok_o);
endmodule

bind ring_fwd_node ring_fwd_node_chk #(
  .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .node_id_i(node_id_i), .err_irq_en_i(err_irq_en_i),
  .up_valid_i(up_valid_i), .up_ready_o(up_ready_o), .up_src_i(up_src_i),
  .up_err_i(up_err_i), .loc_ready_o(loc_ready_o), .dn_valid_o(dn_valid_o),
  .dn_ready_i(dn_ready_i), .dn_src_o(dn_src_o), .dn_addr_o(dn_addr_o),
  .dn_data_o(dn_data_o), .mem_we_o(mem_we_o), .err_irq_o(err_irq_o),
  .ring_ok_o(ring_ok_o)
);

// File: tb/ring_fwd_node_tb_top.sv
module ring_fwd_node_tb_top;
  localparam logic [7:0] MY_ID = 8'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  node_id_i = MY_ID;
  logic        err_irq_en_i = 1'b1;
  logic        ring_clr_i = 1'b0;
  logic        up_valid_i = 1'b0;
  logic        up_ready_o;
  logic [7:0]  up_src_i = '0;
  logic [15:0] up_addr_i = '0;
  logic [31:0] up_data_i = '0;
  logic        up_err_i = 1'b0;
  logic        loc_valid_i = 1'b0;
  logic        loc_ready_o;
  logic [15:0] loc_addr_i = '0;
  logic [31:0] loc_data_i = '0;
  logic        dn_valid_o;
  logic        dn_ready_i = 1'b1;
  logic [7:0]  dn_src_o;
  logic [15:0] dn_addr_o;
  logic [31:0] dn_data_o;
  logic        mem_we_o;
  logic [15:0] mem_addr_o;
  logic [31:0] mem_data_o;
  logic        err_irq_o;
  logic        ring_ok_o;
  logic [15:0] loop_lat_o;
  logic [7:0]  node_id_o;

  always #4 clk = ~clk;

  ring_fwd_node dut_i (.*);

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int irq_cnt = 0;
  int last_acc = 0;
  logic stall_en = 1'b0;
  logic [2:0] stall_pat = '0;
  logic [55:0] dn_q[$];
  logic [47:0] mem_q[$];
  logic [55:0] prev_dn;
  logic prev_stall = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    stall_pat <= stall_pat + 3'd1;
    dn_ready_i <= stall_en ? (stall_pat[1:0] == 2'b11) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: downstream and memory scoreboards, hold check, irq count
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        check(dn_valid_o && {dn_src_o, dn_addr_o, dn_data_o} == prev_dn,
              "R9", "stalled output held", {dn_src_o, dn_addr_o, dn_data_o}, prev_dn);
      prev_stall = dn_valid_o && !dn_ready_i;
      prev_dn = {dn_src_o, dn_addr_o, dn_data_o};
      if (dn_valid_o && dn_ready_i) begin
        if (dn_q.size() == 0)
          check(0, "R3", "unexpected downstream packet", prev_dn, 0);
        else begin
          logic [55:0] e;
          e = dn_q.pop_front();
          check(prev_dn == e, "R2", "downstream packet", prev_dn, e);
        end
      end
      if (mem_we_o) begin
        if (mem_q.size() == 0)
          check(0, "R6", "unexpected memory write", {mem_addr_o, mem_data_o}, 0);
        else begin
          logic [47:0] m;
          m = mem_q.pop_front();
          check({mem_addr_o, mem_data_o} == m, "R6", "memory write",
                {mem_addr_o, mem_data_o}, m);
        end
      end
      if (err_irq_o) irq_cnt++;
    end
  end

  task automatic send_up(input logic [7:0] src, input logic [15:0] a,
                         input logic [31:0] d, input logic err);
    up_valid_i = 1'b1; up_src_i = src; up_addr_i = a; up_data_i = d; up_err_i = err;
    #1;
    forever begin
      if (up_ready_o) begin
        if (!err && src != MY_ID) begin
          dn_q.push_back({src, a, d});
          mem_q.push_back({a, d});
        end
        last_acc = cyc + 1;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    up_valid_i = 1'b0;
  endtask

  task automatic send_loc(input logic [15:0] a, input logic [31:0] d);
    loc_valid_i = 1'b1; loc_addr_i = a; loc_data_i = d;
    #1;
    forever begin
      if (up_valid_i)
        check(!loc_ready_o, "R5", "local held off by upstream", loc_ready_o, 0);
      if (loc_ready_o) begin
        dn_q.push_back({MY_ID, a, d});
        last_acc = cyc + 1;
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    loc_valid_i = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && (dn_q.size() != 0 || mem_q.size() != 0); i++)
      @(negedge clk);
    check(dn_q.size() == 0, "R2", "downstream queue drained", dn_q.size(), 0);
    check(mem_q.size() == 0, "R6", "memory queue drained", mem_q.size(), 0);
  endtask

  initial begin
    fork
      begin
        int t0, t1, irq0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(node_id_o == MY_ID, "R1", "node id readback", node_id_o, MY_ID);
        check(!dn_valid_o && !mem_we_o && !err_irq_o, "R10", "reset outputs",
              {dn_valid_o, mem_we_o, err_irq_o}, 0);
        check(!ring_ok_o && loop_lat_o == 0, "R7", "reset ring flag/latency",
              {ring_ok_o, loop_lat_o}, 0);

        // foreign traffic, no stall
        for (int i = 0; i < 6; i++)
          send_up(8'h10 + 8'(i), 16'h100 + 16'(i), 32'hA000_0000 + i, 1'b0);
        drain();

        // foreign traffic under back-pressure
        stall_en = 1'b1;
        for (int i = 0; i < 8; i++)
          send_up(8'h20 + 8'(i), 16'h200 + 16'(i), 32'hB000_0000 + i, 1'b0);
        drain();

        // contention: upstream wins, local follows
        fork
          send_up(8'h33, 16'h0333, 32'hC0C0_0001, 1'b0);
          send_loc(16'h0444, 32'hD0D0_0002);
        join
        drain();
        stall_en = 1'b0;
        repeat (4) @(negedge clk);

        // own packet dropped: no forward, no write
        send_up(MY_ID, 16'h0555, 32'h1111_2222, 1'b0);
        repeat (3) @(negedge clk);
        check(!dn_valid_o && !mem_we_o, "R3", "own packet absorbed",
              {dn_valid_o, mem_we_o}, 0);
        check(ring_ok_o, "R7", "ring flag set by return", ring_ok_o, 1);

        // clear flag
        ring_clr_i = 1'b1; @(negedge clk); ring_clr_i = 1'b0;
        check(!ring_ok_o, "R7", "ring flag cleared", ring_ok_o, 0);

        // errored packets, irq enabled then disabled
        irq0 = irq_cnt;
        send_up(8'h44, 16'h0666, 32'hEEEE_0001, 1'b1);
        send_up(MY_ID, 16'h0667, 32'hEEEE_0002, 1'b1);
        repeat (3) @(negedge clk);
        check(irq_cnt - irq0 == 2, "R4", "irq pulses with enable", irq_cnt - irq0, 2);
        check(!ring_ok_o, "R7", "errored own packet leaves flag", ring_ok_o, 0);
        err_irq_en_i = 1'b0;
        irq0 = irq_cnt;
        send_up(8'h45, 16'h0668, 32'hEEEE_0003, 1'b1);
        repeat (3) @(negedge clk);
        err_irq_en_i = 1'b1;
        check(irq_cnt == irq0, "R4", "no irq when disabled", irq_cnt - irq0, 0);
        check(!dn_valid_o && !mem_we_o, "R4", "errored packet removed",
              {dn_valid_o, mem_we_o}, 0);
        drain();

        // latency: local send, loop back after a gap
        send_loc(16'h0777, 32'h7777_0001);
        t0 = last_acc;
        drain();
        send_loc(16'h0778, 32'h7777_0002);
        drain();
        repeat (9) @(negedge clk);
        send_up(MY_ID, 16'h0777, 32'h7777_0001, 1'b0);
        t1 = last_acc;
        @(negedge clk);
        check(loop_lat_o == 16'(t1 - t0), "R8", "loop latency",
              loop_lat_o, t1 - t0);
        check(ring_ok_o, "R7", "ring flag after loop", ring_ok_o, 1);
        check(!mem_we_o, "R6", "no memory write for own data", mem_we_o, 0);
        drain();
      end
      begin
        repeat (20000) @(posedge clk);
        check(0, "R2", "watchdog expired", cyc, 20000);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule